// File: doc/BRIEF.md
# Unequal-Set Second-Level Page Translation Buffer

This block is a second-level translation buffer for 2 MB pages. A requester offers a virtual page number on a valid/ready lookup port. One cycle later the block reports either a hit together with the physical page number or a miss. After a page walk, the walker installs a translation through a fill port. A single invalidate-all input discards every translation at once.

The 65 entries are split across seven sets of unequal size. The set is the page number modulo 7. Set 0 has 17 ways and each of sets 1 to 6 has 8 ways. Inside every set, tags are compared only across that set's own ways, and replacement is least-recently-used.

Top module: `xub_top`

## Requirements
- R1: The set of a page number is its value modulo 7. Set 0 keeps up to 17 translations at once and each of sets 1..6 keeps up to 8. A page number carries address bits 47:21 of a 2 MB-page virtual address.
- R2: `rsp_valid` is high in exactly the cycle after a lookup is accepted (`lk_valid` and `lk_ready` both high at a clock edge) and low at all other times.
- R3: A lookup of an installed page number returns `rsp_hit`=1 and the physical page number stored for it. A lookup of any other page number returns `rsp_hit`=0.
- R4: After reset no translation is valid, `rsp_valid` is 0 and `lk_ready` is 1.
- R5: A fill of a page number that is already installed replaces its physical page number in place. Otherwise the fill uses the lowest-numbered invalid way of the set, or the least-recently-used way when the set is full.
- R6: A fill or a lookup hit makes that way the most-recently-used of its set. A lookup miss leaves the recency order unchanged.
- R7: Filling an 18th distinct page into a full set 0 evicts that set's least-recently-used page and no other page.
- R8: `inv_all` makes every translation invalid at the next edge. A fill presented in the same cycle is not installed.
- R9: `lk_ready` is low in any cycle where `fill_en` or `inv_all` is high, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vpn | input | 27 | Page number to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Response is a hit |
| rsp_ppn | output | 19 | Physical page number on a hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 27 | Page number being installed |
| fill_ppn | input | 19 | Physical page number being installed |
| inv_all | input | 1 | Invalidate every translation |

## Verification
The hardest situation to reach from the ports is an eviction whose victim depends on a recency order that hits and misses have changed since the set filled. The stimulus fills one set completely, hits its oldest page, then issues a miss to a page of the same set. The next fill must then evict the second-oldest page. Capacity is probed per set by filling page numbers spaced by 7, so that all of them fall into the same set. Seventeen such pages must all survive in set 0, while set 1 loses its oldest page at the ninth.

// File: rtl/xub_pkg.sv
package xub_pkg;
  localparam int VPN_W      = 27;
  localparam int PPN_W      = 19;
  localparam int NUM_SETS   = 7;
  localparam int BIG_WAYS   = 17;
  localparam int SMALL_WAYS = 8;
  localparam int SET_W      = $clog2(NUM_SETS);

  function automatic logic [SET_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
    return SET_W'(vpn % VPN_W'(NUM_SETS));
  endfunction

  function automatic int ways_of(input int s);
    return (s == 0) ? BIG_WAYS : SMALL_WAYS;
  endfunction
endpackage

// File: rtl/xub_set.sv
module xub_set
  import xub_pkg::*;
#(
  parameter int WAYS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_all,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  localparam int AGE_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(WAYS);

  logic [WAYS-1:0]  valid;
  logic [VPN_W-1:0] tag   [WAYS];
  logic [PPN_W-1:0] pfn   [WAYS];
  logic [AGE_W-1:0] age   [WAYS];
  logic [WAYS*AGE_W-1:0] age_flat;

  logic [WAYS-1:0] lk_match, fill_match;
  logic [IDX_W-1:0] hit_idx, fill_idx, victim_idx, inval_idx, oldest_idx;
  logic any_inval, fill_present;
  logic touch_en;
  logic [IDX_W-1:0] touch_idx;

  always_comb begin
    hit_idx = '0; fill_idx = '0; inval_idx = '0; oldest_idx = '0;
    any_inval = 1'b0;
    for (int j = 0; j < WAYS; j++) begin
      lk_match[j]   = valid[j] && (tag[j] == lk_vpn);
      fill_match[j] = valid[j] && (tag[j] == fill_vpn);
      if (lk_match[j])   hit_idx = IDX_W'(j);
      if (fill_match[j]) fill_idx = IDX_W'(j);
      if (age[j] == AGE_W'(WAYS-1)) oldest_idx = IDX_W'(j);
      age_flat[j*AGE_W +: AGE_W] = age[j];
    end
    for (int j = WAYS-1; j >= 0; j--) begin
      if (!valid[j]) begin
        inval_idx = IDX_W'(j);
        any_inval = 1'b1;
      end
    end
    fill_present = |fill_match;
    victim_idx   = any_inval ? inval_idx : oldest_idx;
    if (!fill_present) fill_idx = victim_idx;
  end

  assign hit       = lk_en && (|lk_match);
  assign hit_ppn   = pfn[hit_idx];
  assign touch_en  = !inv_all && (fill_en || hit);
  assign touch_idx = fill_en ? fill_idx : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int j = 0; j < WAYS; j++) begin
        tag[j] <= '0;
        pfn[j] <= '0;
        age[j] <= AGE_W'(j);
      end
    end else if (inv_all) begin
      valid <= '0;
    end else begin
      if (fill_en) begin
        valid[fill_idx] <= 1'b1;
        tag[fill_idx]   <= fill_vpn;
        pfn[fill_idx]   <= fill_ppn;
      end
      if (touch_en) begin
        for (int j = 0; j < WAYS; j++) begin
          if (IDX_W'(j) == touch_idx)        age[j] <= '0;
          else if (age[j] < age[touch_idx])  age[j] <= age[j] + 1'b1;
        end
      end
    end
  end

  // R3: tags within a set never duplicate, so at most one way matches
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  // R8: invalidate empties the set
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid == '0));
  // R6: a lookup miss leaves recency untouched
  a_r6_miss_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !(|lk_match) && !fill_en && !inv_all) |=> $stable(age_flat));
  // R6: a touched way becomes most recent
  a_r6_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age[$past(touch_idx)] == '0));
  // R5: a fill never reduces the number of valid ways
  a_r5_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all) |=> ($countones(valid) >= $past($countones(valid))));
endmodule

// File: rtl/xub_top.sv
module xub_top
  import xub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_all
);
  logic             lk_fire;
  logic [SET_W-1:0] lk_set, fill_set;
  logic [NUM_SETS-1:0] set_hit;
  logic [PPN_W-1:0]    set_ppn [NUM_SETS];
  logic             sel_hit;
  logic [PPN_W-1:0] sel_ppn;

  assign lk_ready = !fill_en && !inv_all;
  assign lk_fire  = lk_valid && lk_ready;
  assign lk_set   = set_of(lk_vpn);
  assign fill_set = set_of(fill_vpn);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    xub_set #(.WAYS(ways_of(s))) u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (lk_fire && (lk_set == SET_W'(s))),
      .lk_vpn   (lk_vpn),
      .fill_en  (fill_en && (fill_set == SET_W'(s))),
      .fill_vpn (fill_vpn),
      .fill_ppn (fill_ppn),
      .inv_all  (inv_all),
      .hit      (set_hit[s]),
      .hit_ppn  (set_ppn[s])
    );
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_ppn = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (set_hit[s]) begin
        sel_hit = 1'b1;
        sel_ppn = set_ppn[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_hit   <= sel_hit;
      rsp_ppn   <= sel_ppn;
    end
  end

  // R1: only the selected set can report a hit
  a_r1_one_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_hit));
  // R2: response follows an accepted lookup by one cycle
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !rsp_valid);
  // R9: no lookup accepted during maintenance
  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en || inv_all) |-> !lk_ready);
  // R3: a miss response carries no hit
  a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

// File: tb/sim_xub_top.sv
module sim_xub_top;
  import xub_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_en = 1'b0, inv_all = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic lk_ready, rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  xub_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic eh,
                      input logic [PPN_W-1:0] ep, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"}, 32'(rsp_hit), 32'(eh));
    if (eh) chk({req, " ppn"}, 32'(rsp_ppn), 32'(ep));
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  // entry: op(2) 0=lookup 1=fill 2=invalidate, vpn(27), ppn(19), expected hit(1)
  localparam int NV = 12;
  localparam logic [48:0] TBL [NV] = '{
    {2'd1, 27'd3,  19'h00111, 1'b0},
    {2'd0, 27'd3,  19'h00111, 1'b1},
    {2'd0, 27'd10, 19'h00000, 1'b0},
    {2'd1, 27'd10, 19'h00222, 1'b0},
    {2'd0, 27'd10, 19'h00222, 1'b1},
    {2'd0, 27'd3,  19'h00111, 1'b1},
    {2'd1, 27'd3,  19'h00333, 1'b0},
    {2'd0, 27'd3,  19'h00333, 1'b1},
    {2'd1, 27'd4,  19'h7ABCD, 1'b0},
    {2'd0, 27'd4,  19'h7ABCD, 1'b1},
    {2'd2, 27'd0,  19'h00000, 1'b0},
    {2'd0, 27'd4,  19'h00000, 1'b0}
  };

  initial begin
    repeat (1000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R4 lk_ready after reset", 32'(lk_ready), 32'd1);
    rst_n = 1'b1;
    look(27'd5, 1'b0, '0, "R4 empty miss");

    // R3 R5 R8 table walk
    for (int i = 0; i < NV; i++) begin
      case (TBL[i][48:47])
        2'd1: fill(TBL[i][46:20], TBL[i][19:1]);
        2'd2: flush();
        default: look(TBL[i][46:20], TBL[i][0], TBL[i][19:1], "R3 table");
      endcase
    end

    // R9 ready drops during fill, R2 no response to a refused lookup
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 27'd6; fill_ppn = 19'h6; lk_valid = 1'b1; lk_vpn = 27'd6;
    #1 chk("R9 ready low on fill", 32'(lk_ready), 32'd0);
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
    chk("R2 refused lookup gives no response", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R2 idle gives no response", 32'(rsp_valid), 32'd0);

    // R1 set 0 holds 17 pages
    flush();
    for (int i = 0; i < 17; i++) fill(27'(7*i), 19'(i+1));
    for (int i = 0; i < 17; i++) look(27'(7*i), 1'b1, 19'(i+1), "R1 set0 capacity 17");
    // R7 18th page evicts the least recent (page 0, looked up first)
    fill(27'(7*17), 19'h55);
    look(27'd0, 1'b0, '0, "R7 oldest evicted");
    look(27'(7*17), 1'b1, 19'h55, "R7 new page present");
    look(27'd7, 1'b1, 19'd2, "R7 neighbour kept");

    // R1 set 1 holds only 8 pages
    for (int i = 0; i < 8; i++) fill(27'(1+7*i), 19'(16+i));
    for (int i = 0; i < 8; i++) look(27'(1+7*i), 1'b1, 19'(16+i), "R1 set1 capacity 8");
    fill(27'(1+7*8), 19'h99);
    look(27'd1, 1'b0, '0, "R1 set1 ninth evicts");

    // R6 hit refreshes, miss does not
    for (int i = 0; i < 8; i++) fill(27'(2+7*i), 19'(32+i));
    look(27'd2, 1'b1, 19'd32, "R6 refresh oldest");
    look(27'(2+7*20), 1'b0, '0, "R6 miss in set2");
    fill(27'(2+7*8), 19'h77);
    look(27'd9, 1'b0, '0, "R6 second-oldest evicted");
    look(27'd2, 1'b1, 19'd32, "R6 refreshed page kept");

    // R8 invalidate beats a simultaneous fill
    @(negedge clk);
    inv_all = 1'b1; fill_en = 1'b1; fill_vpn = 27'd300; fill_ppn = 19'h3;
    #1 chk("R9 ready low on invalidate", 32'(lk_ready), 32'd0);
    @(negedge clk);
    inv_all = 1'b0; fill_en = 1'b0;
    look(27'd300, 1'b0, '0, "R8 fill dropped");
    look(27'd7, 1'b0, '0, "R8 old page gone");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule